// File: doc/BRIEF.md
# Partial-Width General-Purpose Register File

This block is the integer register storage of a 64-bit CPU datapath. It keeps sixteen 64-bit registers. Each access names a register index and an operand width: the full register, or its low 32, 16 or 8 bits. A second byte view reaches bits 15:8 of the first four registers. That view is kept for older code that treats the second byte of those registers as its own operand.

There are two read ports and one write port. Each read port has its own index, width and high-byte select. The write port has the same three fields, plus a data bus and an enable. One flag, shared by the whole access, tells the block that the instruction uses the extended byte-register encoding. Writes are merged into the old register contents according to the width. A 32-bit write clears the upper half. An 8-bit or 16-bit write keeps every bit it does not cover. When an access combines the high-byte view with the extended encoding, or asks for a high byte it cannot have, the block raises an illegal-operand flag and drops the write.

Read data, the flag and the register array are all registered. Read results and the flag appear one clock after the request.

Top module: `gprf_regfile`

## Requirements
- R1: The file holds 16 registers of 64 bits. A synchronous reset clears every register and drives both read outputs and `illegal_o` to zero.
- R2: The width codes are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. A read returns the low bits of that width, zero-extended to 64 bits, in the cycle after the request.
- R3: A legal 32-bit write stores `wr_data[31:0]` into bits 31:0 of the target and sets bits 63:32 to zero. For example, register 0 holding 0x8000000000000000 becomes 0x000000000000000A after a 32-bit write of 0xA.
- R4: A legal 8-bit write (high select clear) changes only bits 7:0, and a legal 16-bit write changes only bits 15:0. All other bits keep their value. For example, 0x8000000000000000 becomes 0x8000000000000014 after an 8-bit write of 0x14.
- R5: A legal 64-bit write replaces all 64 bits.
- R6: When width code 0 is used with the high select set on register index 0 to 3, the access reaches bits 15:8 of that register. A read returns those bits in output bits 7:0 with zeros above. A write stores `wr_data[7:0]` into bits 15:8 and leaves every other bit unchanged.
- R7: A port access is illegal if its high select is set together with any of: `ext_enc`=1, a register index above 3, or a width code other than 0. The write port counts only while `wr_en`=1. If any port is illegal, `illegal_o` is 1 in the next cycle and no register changes. Otherwise `illegal_o` is 0.
- R8: A read port whose request is illegal returns zero in the next cycle.
- R9: A read of the register being written in the same cycle returns the value held before that write. The new value is seen from the next request on.
- R10: The two read ports are independent and can read different registers, widths and views in the same cycle.
- R11: While `wr_en` is 0, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 width code |
| rd0_hi | input | 1 | Read port 0 high-byte view select |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 width code |
| rd1_hi | input | 1 | Read port 1 high-byte view select |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write width code |
| wr_hi | input | 1 | Write high-byte view select |
| wr_data | input | 64 | Write data, right-aligned |
| ext_enc | input | 1 | Access uses the extended byte-register encoding |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| illegal_o | output | 1 | Illegal-operand flag for the previous access |

## Verification
A wrong merge leaves bad bits inside a register. Those bits stay hidden until a later read covers them. For that reason each write is followed by a full 64-bit read, so stray upper bits show up one cycle after the read request. A flag that fails to suppress a write shows up the same way, through a read of the target. Port-level properties check the flag and the zero-extension directly in the cycle after each request.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  typedef enum logic [1:0] {
    OPW_8  = 2'd0,
    OPW_16 = 2'd1,
    OPW_32 = 2'd2,
    OPW_64 = 2'd3
  } opw_e;

  // A view is illegal when the high byte is selected on a register that has
  // no such view, with a width other than a byte, or with the extended encoding.
  function automatic logic view_illegal(input int unsigned idx,
                                        input int unsigned hi_regs,
                                        input opw_e size,
                                        input logic hi,
                                        input logic ext);
    return hi && (ext || (idx >= hi_regs) || (size != OPW_8));
  endfunction

endpackage

// File: rtl/gprf_write_merge.sv
module gprf_write_merge
  import gprf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] new_data,
  input  opw_e            size,
  input  logic            hi,
  output logic [XLEN-1:0] merged
);

  localparam int W8  = 8;
  localparam int W16 = 16;
  localparam int W32 = 32;

  always_comb begin
    merged = old_val;
    unique case (size)
      OPW_8: begin
        if (hi) merged[W16-1:W8] = new_data[W8-1:0];
        else    merged[W8-1:0]   = new_data[W8-1:0];
      end
      OPW_16: merged[W16-1:0] = new_data[W16-1:0];
      OPW_32: merged = {{(XLEN-W32){1'b0}}, new_data[W32-1:0]};
      OPW_64: merged = new_data;
      default: merged = old_val;
    endcase
  end

endmodule

// File: rtl/gprf_read_view.sv
module gprf_read_view
  import gprf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IDXW    = 4,
  parameter int HI_REGS = 4
) (
  input  logic [XLEN-1:0] entry,
  input  logic [IDXW-1:0] idx,
  input  opw_e            size,
  input  logic            hi,
  input  logic            ext,
  output logic [XLEN-1:0] view,
  output logic            bad
);

  localparam int W8  = 8;
  localparam int W16 = 16;
  localparam int W32 = 32;

  always_comb begin
    bad  = view_illegal(int'(idx), HI_REGS, size, hi, ext);
    view = '0;
    if (!bad) begin
      unique case (size)
        OPW_8:   view[W8-1:0]  = hi ? entry[W16-1:W8] : entry[W8-1:0];
        OPW_16:  view[W16-1:0] = entry[W16-1:0];
        OPW_32:  view[W32-1:0] = entry[W32-1:0];
        OPW_64:  view          = entry;
        default: view          = '0;
      endcase
    end
  end

endmodule

// File: rtl/gprf_regfile.sv
module gprf_regfile
  import gprf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NREGS   = 16,
  parameter int HI_REGS = 4,
  localparam int IDXW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] rd0_idx,
  input  logic [1:0]      rd0_size,
  input  logic            rd0_hi,
  input  logic [IDXW-1:0] rd1_idx,
  input  logic [1:0]      rd1_size,
  input  logic            rd1_hi,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_size,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ext_enc,
  output logic [XLEN-1:0] rd0_data,
  output logic [XLEN-1:0] rd1_data,
  output logic            illegal_o
);

  localparam int NRD = 2;

  logic [XLEN-1:0] regs [NREGS];

  logic [IDXW-1:0] rd_idx  [NRD];
  opw_e            rd_size [NRD];
  logic            rd_hi   [NRD];
  logic [XLEN-1:0] rd_view [NRD];
  logic [NRD-1:0]  rd_bad;
  logic [XLEN-1:0] rd_q    [NRD];

  assign rd_idx[0]  = rd0_idx;
  assign rd_idx[1]  = rd1_idx;
  assign rd_size[0] = opw_e'(rd0_size);
  assign rd_size[1] = opw_e'(rd1_size);
  assign rd_hi[0]   = rd0_hi;
  assign rd_hi[1]   = rd1_hi;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gprf_read_view #(
      .XLEN    (XLEN),
      .IDXW    (IDXW),
      .HI_REGS (HI_REGS)
    ) u_view (
      .entry (regs[rd_idx[p]]),
      .idx   (rd_idx[p]),
      .size  (rd_size[p]),
      .hi    (rd_hi[p]),
      .ext   (ext_enc),
      .view  (rd_view[p]),
      .bad   (rd_bad[p])
    );
  end

  opw_e            wr_sz;
  logic            wr_bad;
  logic            any_bad;
  logic            commit;
  logic [XLEN-1:0] wr_merged;

  assign wr_sz   = opw_e'(wr_size);
  assign wr_bad  = wr_en && view_illegal(int'(wr_idx), HI_REGS, wr_sz, wr_hi, ext_enc);
  assign any_bad = wr_bad || (|rd_bad);
  assign commit  = wr_en && !any_bad;

  gprf_write_merge #(
    .XLEN (XLEN)
  ) u_merge (
    .old_val  (regs[wr_idx]),
    .new_data (wr_data),
    .size     (wr_sz),
    .hi       (wr_hi),
    .merged   (wr_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (commit) begin
      regs[wr_idx] <= wr_merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NRD; p++) rd_q[p] <= '0;
      illegal_o <= 1'b0;
    end else begin
      for (int p = 0; p < NRD; p++) rd_q[p] <= rd_view[p];
      illegal_o <= any_bad;
    end
  end

  assign rd0_data = rd_q[0];
  assign rd1_data = rd_q[1];

endmodule

// File: rtl/gprf_regfile_chk.sv
module gprf_regfile_chk #(
  parameter int XLEN = 64,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      rd0_size,
  input logic            rd0_hi,
  input logic [1:0]      rd1_size,
  input logic            rd1_hi,
  input logic            wr_en,
  input logic            wr_hi,
  input logic            ext_enc,
  input logic [XLEN-1:0] rd0_data,
  input logic [XLEN-1:0] rd1_data,
  input logic            illegal_o
);

  AST_RD0_BYTE_NARROW: assert property (@(posedge clk) disable iff (rst)
    (rd0_size == 2'd0) |=> (rd0_data[XLEN-1:8] == '0)); // R2
  AST_RD1_HALF_NARROW: assert property (@(posedge clk) disable iff (rst)
    (rd1_size == 2'd1) |=> (rd1_data[XLEN-1:16] == '0)); // R2
  AST_WR_HI_EXT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hi && ext_enc) |=> illegal_o); // R7
  AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!rd0_hi && !rd1_hi && !(wr_en && wr_hi)) |=> !illegal_o); // R7
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd0_hi && ext_enc) |=> (rd0_data == '0)); // R8

endmodule

bind gprf_regfile gprf_regfile_chk #(
  .XLEN (XLEN),
  .IDXW (IDXW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd0_size  (rd0_size),
  .rd0_hi    (rd0_hi),
  .rd1_size  (rd1_size),
  .rd1_hi    (rd1_hi),
  .wr_en     (wr_en),
  .wr_hi     (wr_hi),
  .ext_enc   (ext_enc),
  .rd0_data  (rd0_data),
  .rd1_data  (rd1_data),
  .illegal_o (illegal_o)
);

// File: tb/gprf_regfile_tb.sv
module gprf_regfile_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [1:0]  rd0_size = '0, rd1_size = '0, wr_size = '0;
  logic        rd0_hi = 1'b0, rd1_hi = 1'b0, wr_hi = 1'b0, wr_en = 1'b0, ext_enc = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd0_data, rd1_data;
  logic        illegal_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gprf_regfile u_dut (
    .clk (clk), .rst (rst),
    .rd0_idx (rd0_idx), .rd0_size (rd0_size), .rd0_hi (rd0_hi),
    .rd1_idx (rd1_idx), .rd1_size (rd1_size), .rd1_hi (rd1_hi),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_size (wr_size), .wr_hi (wr_hi),
    .wr_data (wr_data), .ext_enc (ext_enc),
    .rd0_data (rd0_data), .rd1_data (rd1_data), .illegal_o (illegal_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%016h expected 0x%016h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; wr_hi = 0; ext_enc = 0; rd0_hi = 0; rd1_hi = 0;
  endtask

  task automatic wr(input int idx, input int sz, input logic hi, input logic ext,
                    input logic [63:0] d);
    idle();
    wr_en = 1; wr_idx = 4'(idx); wr_size = 2'(sz); wr_hi = hi; ext_enc = ext; wr_data = d;
    step();
    idle();
  endtask

  task automatic rd(input int idx, input int sz, input logic hi, output logic [63:0] d);
    idle();
    rd0_idx = 4'(idx); rd0_size = 2'(sz); rd0_hi = hi;
    step();
    d = rd0_data;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 illegal after reset", 64'(illegal_o), 64'h0);
    check("R1 rd0 after reset", rd0_data, 64'h0);
    for (int i = 0; i < 16; i += 5) begin
      rd(i, 3, 0, d);
      check("R1 register zero", d, 64'h0);
    end
  endtask

  task automatic t_widths();
    logic [63:0] d;
    wr(0, 3, 0, 0, 64'h8000_0000_0000_0000);
    rd(0, 3, 0, d); check("R5 full write", d, 64'h8000_0000_0000_0000);
    wr(0, 2, 0, 0, 64'hFFFF_FFFF_0000_000A);
    rd(0, 3, 0, d); check("R3 32-bit clears upper", d, 64'h0000_0000_0000_000A);
    wr(0, 3, 0, 0, 64'h8000_0000_0000_0000);
    wr(0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FF14);
    rd(0, 3, 0, d); check("R4 8-bit keeps rest", d, 64'h8000_0000_0000_0014);
    wr(7, 3, 0, 0, 64'h1234_5678_9ABC_DEF0);
    wr(7, 1, 0, 0, 64'hAAAA_AAAA_AAAA_5555);
    rd(7, 3, 0, d); check("R4 16-bit keeps rest", d, 64'h1234_5678_9ABC_5555);
  endtask

  task automatic t_reads();
    logic [63:0] d;
    wr(9, 3, 0, 0, 64'h1122_3344_5566_7788);
    rd(9, 0, 0, d); check("R2 byte read", d, 64'h88);
    rd(9, 1, 0, d); check("R2 half read", d, 64'h7788);
    rd(9, 2, 0, d); check("R2 word read", d, 64'h5566_7788);
  endtask

  task automatic t_high();
    logic [63:0] d;
    wr(2, 3, 0, 0, 64'h0102_0304_0506_0708);
    rd(2, 0, 1, d); check("R6 high-byte read", d, 64'h07);
    wr(2, 0, 1, 0, 64'h0000_0000_0000_00AB);
    rd(2, 3, 0, d); check("R6 high-byte write", d, 64'h0102_0304_0506_AB08);
  endtask

  task automatic t_illegal();
    logic [63:0] d;
    wr(1, 3, 0, 0, 64'h1111_2222_3333_4444);
    wr(1, 0, 1, 1, 64'hAA);
    check("R7 flag hi+ext write", 64'(illegal_o), 64'h1);
    rd(1, 3, 0, d); check("R7 write suppressed", d, 64'h1111_2222_3333_4444);
    check("R7 flag clears", 64'(illegal_o), 64'h0);
    wr(6, 3, 0, 0, 64'h6666);
    wr(6, 0, 1, 0, 64'h77);
    check("R7 flag hi on index 6", 64'(illegal_o), 64'h1);
    wr(1, 1, 1, 0, 64'h9999);
    check("R7 flag hi with 16-bit", 64'(illegal_o), 64'h1);
    rd(6, 3, 0, d); check("R7 index 6 unchanged", d, 64'h6666);
    rd(1, 3, 0, d); check("R7 reg1 unchanged", d, 64'h1111_2222_3333_4444);
    idle();
    rd0_idx = 4'd1; rd0_size = 2'd0; rd0_hi = 1; ext_enc = 1;
    step();
    check("R8 illegal read zero", rd0_data, 64'h0);
    check("R7 flag on read port", 64'(illegal_o), 64'h1);
    idle();
    rd0_hi = 1; rd0_idx = 4'd1; rd0_size = 2'd0; ext_enc = 1;
    wr_en = 1; wr_idx = 4'd4; wr_size = 2'd3; wr_data = 64'hDEAD;
    step();
    idle();
    rd(4, 3, 0, d); check("R7 read-port fault blocks write", d, 64'h0);
    wr(12, 0, 0, 1, 64'h5A);
    check("R7 ext without hi legal", 64'(illegal_o), 64'h0);
    rd(12, 3, 0, d); check("R7 ext byte write lands", d, 64'h5A);
  endtask

  task automatic t_rdw();
    logic [63:0] d;
    wr(3, 3, 0, 0, 64'hAAAA_0000_0000_0001);
    idle();
    wr_en = 1; wr_idx = 4'd3; wr_size = 2'd3; wr_data = 64'hBBBB_0000_0000_0002;
    rd0_idx = 4'd3; rd0_size = 2'd3;
    step();
    idle();
    check("R9 old value same cycle", rd0_data, 64'hAAAA_0000_0000_0001);
    rd(3, 3, 0, d); check("R9 new value next", d, 64'hBBBB_0000_0000_0002);
  endtask

  task automatic t_dual();
    idle();
    rd0_idx = 4'd9; rd0_size = 2'd3;
    rd1_idx = 4'd2; rd1_size = 2'd0; rd1_hi = 1;
    step();
    check("R10 port0", rd0_data, 64'h1122_3344_5566_7788);
    check("R10 port1 high byte", rd1_data, 64'hAB);
    idle();
  endtask

  task automatic t_noen();
    logic [63:0] d;
    idle();
    wr_en = 0; wr_idx = 4'd9; wr_size = 2'd3; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    step();
    rd(9, 3, 0, d); check("R11 no write without enable", d, 64'h1122_3344_5566_7788);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_widths();
    t_reads();
    t_high();
    t_illegal();
    t_rdw();
    t_dual();
    t_noen();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule